// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Controller

This block holds the eight-bit software status register of a serial NOR flash and makes every write-protection decision for it. The serial front end decodes commands and hands this block single-cycle events: write enable, write disable, status-write arming, a status write carrying its data byte, any other command, completion of a program or erase, and the end of a sequential word-programming run. It also sees the write-protect pin (active low), a live busy flag from the array sequencer, and a candidate program or erase request made of an operation kind and a 22-bit byte address.

It returns the status byte for status reads, the write-enable flag, and a grant for the current request. The grant is combinational by default, so the front end can decide in the same cycle it presents the request. A parameter can register it instead. Protection is a top fraction of the address space chosen by three protect bits. A fourth protect bit is stored but only affects whole-chip erase. A lock bit freezes the protect bits and itself while the protect pin is held low.

Top module: `flsr_top`

## Requirements
- R1: After reset the status byte reads 0x1C when busy is low: WEL, AAI-sequence and lock bits are 0, BP2..BP0 are 1 and BP3 is 0.
- R2: Status byte layout: bit 0 mirrors `busy_in` in the same cycle, bit 1 is WEL, bits 5..2 are BP3..BP0, bit 6 is the sequential-programming flag, and bit 7 is the lock bit.
- R3: `cmd_wren` sets WEL on the next cycle. `cmd_wrdi`, `op_done`, `seq_exit` and `cmd_wrsr` each clear it, and a clear wins over a set in the same cycle.
- R4: A status write takes effect only when the most recent earlier command event was `cmd_wren` or `cmd_ewsr`. Any other command event in between, including a request, cancels the arming.
- R5: With `wp_n` low and the lock bit 1, a status write leaves BP3..BP0 and the lock bit unchanged (WEL is still cleared). With `wp_n` high, a status write may clear the lock bit.
- R6: An accepted status write loads BP3..BP0 from data bits 5..2 and the lock bit from data bit 7. Data bits 6, 1 and 0 have no effect. Protect bits and the lock bit may be set in one write.
- R7: Let p be BP2..BP0. If p is 0, nothing is protected. Otherwise an address is protected when it is at or above 2^22 − 2^22/2^(7−p). So p=1 protects 0x3F0000 and up, p=6 protects 0x200000 and up, and p=7 protects everything. BP3 plays no part in this check.
- R8: `req_kind` codes: 0 byte program, 1 sequential word program, 2 4 KiB erase, 3 32 KiB erase, 4 64 KiB erase, 5 chip erase; 6 and 7 are always denied. A request is granted only if WEL is 1. Program kinds are checked at the given address. Erase kinds are checked at the address aligned down to the region size. Chip erase requires BP3..BP0 to be all zero.
- R9: A granted sequential-word request sets status bit 6. `seq_exit` or `cmd_wrdi` clears it.
- R10: A request in the same cycle as an accepted status write is judged against the protect bits held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_n | input | 1 | Write-protect pin, low enables the lock |
| busy_in | input | 1 | Array operation in progress |
| cmd_wren | input | 1 | Write-enable command event |
| cmd_wrdi | input | 1 | Write-disable command event |
| cmd_ewsr | input | 1 | Status-write arming command event |
| cmd_wrsr | input | 1 | Status-write command event, ends with chip-select rise |
| wrsr_data | input | 8 | Data byte of the status write |
| cmd_other | input | 1 | Any other decoded command |
| op_done | input | 1 | Byte program or erase completed |
| seq_exit | input | 1 | Sequential word programming finished or left |
| req_valid | input | 1 | Program or erase request present |
| req_kind | input | 3 | Operation kind of the request |
| req_addr | input | ADDR_W | Byte address of the request |
| status_q | output | 8 | Status byte |
| wel | output | 1 | Write-enable flag |
| req_grant | output | 1 | Request is allowed |

## Verification
Two functions can fall in the same cycle. The first pair is an accepted status write that changes the protect bits and a request checked against those bits. The bench raises both in one cycle after arming with an enable-write-status event. It expects the grant to follow the old bits and the status byte to show the new bits one cycle later. The second pair is a write enable and a completion event in the same cycle, which must leave WEL clear. A behavioural model updated at every rising edge supplies the expected status byte and grant, and these are compared at every falling edge.

// File: rtl/flsr_pkg.sv
package flsr_pkg;
   typedef enum logic [2:0] {
      OP_BYTE    = 3'd0,
      OP_WORDSEQ = 3'd1,
      OP_SECT    = 3'd2,
      OP_BLK_S   = 3'd3,
      OP_BLK_L   = 3'd4,
      OP_CHIP    = 3'd5
   } op_kind_e;

   localparam int STAT_W      = 8;
   localparam int PB_W        = 4;
   localparam int RANGE_W     = 3;
   localparam int POS_BUSY    = 0;
   localparam int POS_WEL     = 1;
   localparam int POS_PB_LO   = 2;
   localparam int POS_SEQ     = 6;
   localparam int POS_LOCK    = 7;
   localparam logic [PB_W-1:0] PB_RESET = 4'b0111;
endpackage

// File: rtl/flsr_wel_ctl.sv
module flsr_wel_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_wren,
   input  logic cmd_wrdi,
   input  logic cmd_ewsr,
   input  logic cmd_wrsr,
   input  logic cmd_other,
   input  logic req_valid,
   input  logic op_done,
   input  logic seq_exit,
   input  logic seq_start,
   output logic wel_q,
   output logic armed_q,
   output logic seq_q
);
   logic wel_clr;
   logic arm_set;
   logic arm_clr;
   logic seq_clr;

   assign wel_clr = cmd_wrdi | cmd_wrsr | op_done | seq_exit;
   assign arm_set = cmd_wren | cmd_ewsr;
   assign arm_clr = cmd_wrdi | cmd_wrsr | cmd_other | req_valid;
   assign seq_clr = cmd_wrdi | seq_exit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q   <= 1'b0;
         armed_q <= 1'b0;
         seq_q   <= 1'b0;
      end else begin
         if (wel_clr)
            wel_q <= 1'b0;
         else if (cmd_wren)
            wel_q <= 1'b1;

         if (arm_set)
            armed_q <= 1'b1;
         else if (arm_clr)
            armed_q <= 1'b0;

         if (seq_clr)
            seq_q <= 1'b0;
         else if (seq_start)
            seq_q <= 1'b1;
      end
   end
endmodule

// File: rtl/flsr_prot_bits.sv
module flsr_prot_bits
   import flsr_pkg::*;
#(
   parameter logic [PB_W-1:0] RESET_VAL = PB_RESET
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wp_n,
   input  logic            wr_req,
   input  logic [PB_W-1:0] din_pb,
   input  logic            din_lock,
   output logic [PB_W-1:0] pb_q,
   output logic            lock_q
);
   logic frozen;
   logic wr_ok;

   assign frozen = ~wp_n & lock_q;
   assign wr_ok  = wr_req & ~frozen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pb_q   <= RESET_VAL;
         lock_q <= 1'b0;
      end else if (wr_ok) begin
         pb_q   <= din_pb;
         lock_q <= din_lock;
      end
   end
endmodule

// File: rtl/flsr_range_chk.sv
module flsr_range_chk #(
   parameter int ADDR_W = 22,
   parameter int SEL_W  = 3
) (
   input  logic [SEL_W-1:0]  code,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int NCODE   = 2 ** SEL_W;
   localparam int MAX_TOP = NCODE - 2;

   logic [NCODE-1:0] top_ones;
   logic [SEL_W-1:0] sel;

   if (ADDR_W < MAX_TOP) begin : g_bad_width
      $error("flsr_range_chk: ADDR_W too small for protect code width");
   end

   assign top_ones[0]       = 1'b1;
   assign top_ones[NCODE-1] = 1'b0;

   for (genvar g = 1; g <= MAX_TOP; g++) begin : g_top
      assign top_ones[g] = &addr[ADDR_W-1 -: g];
   end

   assign sel = ~code;
   assign hit = top_ones[sel];
endmodule

// File: rtl/flsr_top.sv
module flsr_top
   import flsr_pkg::*;
#(
   parameter int ADDR_W    = 22,
   parameter int SECT_LG   = 12,
   parameter int BLK_S_LG  = 15,
   parameter int BLK_L_LG  = 16,
   parameter bit GRANT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_n,
   input  logic              busy_in,
   input  logic              cmd_wren,
   input  logic              cmd_wrdi,
   input  logic              cmd_ewsr,
   input  logic              cmd_wrsr,
   input  logic [7:0]        wrsr_data,
   input  logic              cmd_other,
   input  logic              op_done,
   input  logic              seq_exit,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   output logic [7:0]        status_q,
   output logic              wel,
   output logic              req_grant
);
   if (!(SECT_LG < BLK_S_LG && BLK_S_LG < BLK_L_LG && BLK_L_LG < ADDR_W)) begin : g_bad_sizes
      $error("flsr_top: erase region sizes must grow and fit the address");
   end

   localparam logic [ADDR_W-1:0] SECT_MASK  = ADDR_W'((64'd1 << SECT_LG) - 64'd1);
   localparam logic [ADDR_W-1:0] BLK_S_MASK = ADDR_W'((64'd1 << BLK_S_LG) - 64'd1);
   localparam logic [ADDR_W-1:0] BLK_L_MASK = ADDR_W'((64'd1 << BLK_L_LG) - 64'd1);

   logic            armed;
   logic            seq_flag;
   logic [PB_W-1:0] pb;
   logic            lock;
   logic            hit;
   logic            grant_c;
   logic            seq_start;
   logic [ADDR_W-1:0] chk_addr;
   op_kind_e        kind;
   logic            unused_data;

   assign kind        = op_kind_e'(req_kind);
   assign unused_data = ^{wrsr_data[6], wrsr_data[1:0]};

   flsr_wel_ctl u_wel (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wren  (cmd_wren),
      .cmd_wrdi  (cmd_wrdi),
      .cmd_ewsr  (cmd_ewsr),
      .cmd_wrsr  (cmd_wrsr),
      .cmd_other (cmd_other),
      .req_valid (req_valid),
      .op_done   (op_done),
      .seq_exit  (seq_exit),
      .seq_start (seq_start),
      .wel_q     (wel),
      .armed_q   (armed),
      .seq_q     (seq_flag)
   );

   flsr_prot_bits #(.RESET_VAL(PB_RESET)) u_prot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wp_n     (wp_n),
      .wr_req   (cmd_wrsr & armed),
      .din_pb   (wrsr_data[POS_PB_LO +: PB_W]),
      .din_lock (wrsr_data[POS_LOCK]),
      .pb_q     (pb),
      .lock_q   (lock)
   );

   always_comb begin
      unique case (kind)
         OP_SECT:  chk_addr = req_addr & ~SECT_MASK;
         OP_BLK_S: chk_addr = req_addr & ~BLK_S_MASK;
         OP_BLK_L: chk_addr = req_addr & ~BLK_L_MASK;
         default:  chk_addr = req_addr;
      endcase
   end

   flsr_range_chk #(.ADDR_W(ADDR_W), .SEL_W(RANGE_W)) u_range (
      .code (pb[RANGE_W-1:0]),
      .addr (chk_addr),
      .hit  (hit)
   );

   always_comb begin
      case (kind)
         OP_BYTE, OP_WORDSEQ:      grant_c = req_valid & wel & ~hit;
         OP_SECT, OP_BLK_S, OP_BLK_L: grant_c = req_valid & wel & ~hit;
         OP_CHIP:                  grant_c = req_valid & wel & (pb == '0);
         default:                  grant_c = 1'b0;
      endcase
   end

   assign seq_start = grant_c & (kind == OP_WORDSEQ);

   if (GRANT_REG) begin : g_grant_reg
      logic grant_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            grant_q <= 1'b0;
         else
            grant_q <= grant_c;
      end
      assign req_grant = grant_q;
   end else begin : g_grant_comb
      assign req_grant = grant_c;
   end

   always_comb begin
      status_q                        = '0;
      status_q[POS_BUSY]              = busy_in;
      status_q[POS_WEL]               = wel;
      status_q[POS_PB_LO +: PB_W]     = pb;
      status_q[POS_SEQ]               = seq_flag;
      status_q[POS_LOCK]              = lock;
   end
endmodule

// File: rtl/flsr_chk.sv
module flsr_chk #(
   parameter bit GRANT_REG = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wp_n,
   input logic       cmd_wren,
   input logic       cmd_wrdi,
   input logic       cmd_wrsr,
   input logic [7:0] wrsr_data,
   input logic       op_done,
   input logic       seq_exit,
   input logic       req_valid,
   input logic       req_grant,
   input logic       wel,
   input logic       armed,
   input logic [7:0] status_q
);
   // R1
   reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> status_q[7:1] == 7'b0001110);

   // R3
   wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wrdi || op_done || seq_exit || cmd_wrsr) |=> !wel);

   // R3
   wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wren && !(cmd_wrdi || op_done || seq_exit || cmd_wrsr)) |=> wel);

   // R4
   unarmed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wrsr && !armed) |=>
         (status_q[7] == $past(status_q[7]) && status_q[5:2] == $past(status_q[5:2])));

   // R5
   locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wrsr && !wp_n && status_q[7]) |=>
         (status_q[7] == $past(status_q[7]) && status_q[5:2] == $past(status_q[5:2])));

   // R6
   write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wrsr && armed && (wp_n || !status_q[7])) |=>
         (status_q[5:2] == $past(wrsr_data[5:2]) && status_q[7] == $past(wrsr_data[7])));

   // R9
   seq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_exit || cmd_wrdi) |=> !status_q[6]);

   if (GRANT_REG) begin : g_reg
      // R8
      no_wel_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !wel) |=> !req_grant);
   end else begin : g_comb
      // R8
      no_wel_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !wel) |-> !req_grant);
   end
endmodule

bind flsr_top flsr_chk #(.GRANT_REG(GRANT_REG)) u_flsr_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wp_n      (wp_n),
   .cmd_wren  (cmd_wren),
   .cmd_wrdi  (cmd_wrdi),
   .cmd_wrsr  (cmd_wrsr),
   .wrsr_data (wrsr_data),
   .op_done   (op_done),
   .seq_exit  (seq_exit),
   .req_valid (req_valid),
   .req_grant (req_grant),
   .wel       (wel),
   .armed     (armed),
   .status_q  (status_q)
);

// File: tb/tb_flsr_top.sv
module tb_flsr_top;
   localparam int AW   = 22;
   localparam int SPAN = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wp_n = 1'b1;
   logic          busy_in = 1'b0;
   logic          cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_ewsr = 1'b0, cmd_wrsr = 1'b0;
   logic [7:0]    wrsr_data = 8'h00;
   logic          cmd_other = 1'b0, op_done = 1'b0, seq_exit = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_kind = 3'd0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    status_q;
   logic          wel;
   logic          req_grant;

   int    checks = 0;
   int    errors = 0;
   string phase = "R1";
   bit    done = 1'b0;

   // reference state
   bit       m_wel, m_armed, m_seq, m_lock;
   bit [3:0] m_pb;

   always #10 clk = ~clk;

   flsr_top dut (
      .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .busy_in(busy_in),
      .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_ewsr(cmd_ewsr),
      .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .cmd_other(cmd_other),
      .op_done(op_done), .seq_exit(seq_exit), .req_valid(req_valid),
      .req_kind(req_kind), .req_addr(req_addr), .status_q(status_q),
      .wel(wel), .req_grant(req_grant)
   );

   function automatic bit m_allow(input int k, input int unsigned a);
      int unsigned lo;
      int unsigned base;
      if (!req_valid || !m_wel) return 1'b0;
      if (m_pb[2:0] == 3'd0) lo = SPAN;
      else lo = SPAN - (SPAN >> (7 - int'(m_pb[2:0])));
      case (k)
         0, 1: base = a;
         2: base = a - (a % 4096);
         3: base = a - (a % 32768);
         4: base = a - (a % 65536);
         5: return m_pb == 4'd0;
         default: return 1'b0;
      endcase
      return base < lo;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_wel = 0; m_armed = 0; m_seq = 0; m_lock = 0; m_pb = 4'b0111;
      end else begin
         bit g;
         bit take;
         g    = m_allow(int'(req_kind), int'(req_addr));
         take = cmd_wrsr && m_armed && !(!wp_n && m_lock);
         if (cmd_wrdi || seq_exit) m_seq = 0;
         else if (g && req_kind == 3'd1) m_seq = 1;
         if (cmd_wrdi || cmd_wrsr || op_done || seq_exit) m_wel = 0;
         else if (cmd_wren) m_wel = 1;
         if (cmd_wren || cmd_ewsr) m_armed = 1;
         else if (cmd_wrdi || cmd_wrsr || cmd_other || req_valid) m_armed = 0;
         if (take) begin
            m_pb   = wrsr_data[5:2];
            m_lock = wrsr_data[7];
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [7:0] exp_s;
         exp_s = {m_lock, m_seq, m_pb, m_wel, busy_in};
         checks++;
         if (status_q !== exp_s) begin
            errors++;
            $display("FAIL %s status actual=%02h expected=%02h", phase, status_q, exp_s);
         end
         if (req_valid) begin
            bit eg;
            eg = m_allow(int'(req_kind), int'(req_addr));
            checks++;
            if (req_grant !== eg) begin
               errors++;
               $display("FAIL %s grant actual=%0b expected=%0b", phase, req_grant, eg);
            end
         end
      end
   end

   task automatic check_val(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic do_wren();  cmd_wren = 1; step(); cmd_wren = 0; endtask
   task automatic do_wrdi();  cmd_wrdi = 1; step(); cmd_wrdi = 0; endtask
   task automatic do_ewsr();  cmd_ewsr = 1; step(); cmd_ewsr = 0; endtask
   task automatic do_other(); cmd_other = 1; step(); cmd_other = 0; endtask
   task automatic do_wrsr(input logic [7:0] d);
      cmd_wrsr = 1; wrsr_data = d; step(); cmd_wrsr = 0; wrsr_data = 8'h00;
   endtask
   task automatic set_pb(input logic [7:0] d);
      do_ewsr(); do_wrsr(d);
   endtask
   task automatic ask(input string tag, input int k, input int unsigned a, input bit exp);
      req_valid = 1; req_kind = 3'(k); req_addr = AW'(a);
      #5;
      check_val(tag, {7'd0, req_grant}, {7'd0, exp});
      step();
      req_valid = 0;
   endtask

   initial begin
      #2000000;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      // R1 reset value
      phase = "R1";
      check_val("R1 reset", status_q, 8'h1C);
      // R2 busy mirror in bit 0
      phase = "R2";
      busy_in = 1; #2;
      check_val("R2 busy bit", status_q, 8'h1D);
      step(); busy_in = 0;
      // R3 write-enable set / clear / collision
      phase = "R3";
      do_wren();  check_val("R3 wren", status_q, 8'h1E);
      do_wrdi();  check_val("R3 wrdi", status_q, 8'h1C);
      do_wren();
      cmd_wren = 1; op_done = 1; step(); cmd_wren = 0; op_done = 0;
      check_val("R3 clear beats set", status_q, 8'h1C);
      // R4 arming
      phase = "R4";
      do_wren(); do_other(); do_wrsr(8'h00);
      check_val("R4 unarmed write", status_q, 8'h1C);
      set_pb(8'h00);
      check_val("R4 armed write", status_q, 8'h00);
      // R6 field loading
      phase = "R6";
      set_pb(8'h43); check_val("R6 ignored bits", status_q, 8'h00);
      set_pb(8'hFF); check_val("R6 load all", status_q, 8'hBC);
      set_pb(8'h00); check_val("R6 unlock wp high", status_q, 8'h00);
      // R7 range decode
      phase = "R7";
      for (int p = 1; p <= 7; p++) begin
         int unsigned lo;
         lo = SPAN - (SPAN >> (7 - p));
         set_pb(8'(p << 2));
         do_wren();
         if (lo != 0) begin
            ask("R7 below", 0, lo - 1, 1'b1);
            ask("R7 at boundary", 0, lo, 1'b0);
            ask("R7 sector inside", 2, lo + 4095, 1'b0);
            ask("R7 block64 aligned", 4, lo - 1, 1'b1);
         end else begin
            ask("R7 all protected", 0, 0, 1'b0);
            ask("R7 all top", 1, SPAN - 1, 1'b0);
         end
      end
      // R8 write enable and chip erase
      phase = "R8";
      set_pb(8'h00);
      ask("R8 no wel", 0, 0, 1'b0);
      do_wren();
      ask("R8 chip ok", 5, 0, 1'b1);
      set_pb(8'h20);
      check_val("R8 bp3 only", status_q, 8'h20);
      do_wren();
      ask("R8 chip bp3", 5, 0, 1'b0);
      ask("R8 bp3 no range", 0, SPAN - 1, 1'b1);
      ask("R8 bad kind", 6, 0, 1'b0);
      do_wrdi();
      // R9 sequential programming flag
      phase = "R9";
      set_pb(8'h00);
      do_wren();
      ask("R9 seq grant", 1, 32'h100, 1'b1);
      check_val("R9 seq set", status_q, 8'h42);
      seq_exit = 1; step(); seq_exit = 0;
      check_val("R9 seq exit", status_q, 8'h00);
      do_wren();
      ask("R9 seq again", 1, 32'h200, 1'b1);
      do_wrdi();
      check_val("R9 wrdi clears", status_q, 8'h00);
      do_wren();
      ask("R3 erase", 2, 32'h1000, 1'b1);
      op_done = 1; step(); op_done = 0;
      check_val("R3 op done", status_q, 8'h00);
      // R5 lock behaviour
      phase = "R5";
      wp_n = 0;
      set_pb(8'h84);
      check_val("R5 set lock and bp", status_q, 8'h84);
      do_wren();
      ask("R5 protected top", 0, 32'h3F0000, 1'b0);
      do_wren();
      do_wrsr(8'h00);
      check_val("R5 locked after wren", status_q, 8'h84);
      set_pb(8'h80);
      check_val("R5 locked after arm", status_q, 8'h84);
      wp_n = 1;
      set_pb(8'h00);
      check_val("R5 wp high unlock", status_q, 8'h00);
      // R10 write and request in the same cycle
      phase = "R10";
      set_pb(8'h1C);
      do_wren();
      do_ewsr();
      cmd_wrsr = 1; wrsr_data = 8'h00;
      req_valid = 1; req_kind = 3'd0; req_addr = '0;
      #5;
      check_val("R10 old bits used", {7'd0, req_grant}, 8'h00);
      step();
      cmd_wrsr = 0; req_valid = 0;
      check_val("R10 new bits", status_q, 8'h00);
      do_wren();
      ask("R10 after write", 0, 0, 1'b1);
      step();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule